// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a stereo pair of 16-bit samples into a serial bit stream, one bit per bit-clock period. It is a slave: an external master supplies the bit clock, a left/right frame clock and a word clock. The block does not drive any of these clocks. All three clock inputs are sampled in the block's own system clock domain, which must run several times faster than the bit clock. The block finds the data-launch edge of the bit clock and then decides, for each bit period, whether that period carries a sample bit or a zero.

A 2-bit format input selects one of four ways of placing each 16-bit word inside its half-frame:
- Left-justified, with the MSB in the first bit period.
- Left-justified, with the MSB one bit period late.
- Right-justified, with the MSB sixteen bit periods late in a half-frame of 32 bit periods.
- Word-clock-started: each word begins on a word-clock pulse instead of a frame-clock edge.

A polarity input chooses which bit-clock edge launches data. A mute input replaces the words with zeros.

At the start of every frame the block captures the incoming sample pair, the format and the mute setting. It then pulses a one-cycle request so that the source can present the next pair.

Top module: `aso_serial_tx`

## Requirements
- R1: After reset, and until the first rising edge of the frame clock, `sdata` is 0 and `sample_req` is low.
- R2: With `bclk_pol` = 0, `sdata` changes only after a falling `bclk` edge and holds across the rising edge. With `bclk_pol` = 1 the two edges swap roles. The polarity is taken at reset and at each frame start.
- R3: Format 2'b00: the word's MSB is sent in bit period 0 after a frame-clock transition. The 16 bits follow MSB first.
- R4: Format 2'b01: the MSB is sent in bit period 1 after the frame-clock transition, so the word occupies periods 1 to 16.
- R5: Format 2'b10: the MSB is sent in bit period 16 after the frame-clock transition, so the word occupies periods 16 to 31.
- R6: Format 2'b11: frame-clock edges do not start words. A word starts, MSB first, in the bit period where `wclk` is first seen high. Its channel is taken from the frame-clock level in that period.
- R7: The left sample is sent while `lrclk` is high, and the right sample is sent while `lrclk` is low.
- R8: Every bit period outside the 16 data bits carries 0.
- R9: When mute is in effect, every bit period carries 0.
- R10: Changes of `fmt` or `mute` during a frame have no effect until the next rising edge of `lrclk`.
- R11: `left_in` and `right_in` are both captured at the rising edge of `lrclk`. Later changes do not alter the words of that frame.
- R12: Each frame start produces exactly one `sample_req` pulse, one system clock wide, on the cycle after the frame start is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | Frame clock: high for the left half, low for the right half |
| wclk | input | 1 | Word-start pulse used by format 2'b11 |
| bclk_pol | input | 1 | 0: launch on the falling edge. 1: launch on the rising edge |
| fmt | input | 2 | Framing format select |
| mute | input | 1 | 1 forces zero words |
| left_in | input | 16 | Left sample of the next pair |
| right_in | input | 16 | Right sample of the next pair |
| sdata | output | 1 | Serial data out |
| sample_req | output | 1 | One-cycle request for the next sample pair |

## Verification
The bench checks every bit period twice: once just before the sampling edge and once just before the next launch edge. A design that launched on the wrong edge would show a changed bit at the second check.

The bench goes after these corner cases, each with its own failure signature:
- Word edges in all four formats. An off-by-one delay would shift the whole word by a bit and leave an extra or missing bit at its ends.
- Word-clock pulses placed away from the frame-clock edges. A design that started words on the frame clock in the word-clock format would send the MSB four periods early.
- Changes to format, mute and the sample inputs partway through a frame. A design that captured them continuously would corrupt the word already on the line.
- The request strobe. A stretched or missing strobe changes the count of request cycles per frame.

// File: rtl/aso_pkg.sv
// Shared definitions for the serial audio transmitter.
package aso_pkg;

    // Framing formats; the encoding is the value on the fmt port.
    typedef enum logic [1:0] {
        FMT_LJ     = 2'b00,  // left-justified, MSB in period 0
        FMT_LJ_DLY = 2'b01,  // left-justified, MSB in period 1
        FMT_RJ     = 2'b10,  // right-justified within the half-frame
        FMT_WCK    = 2'b11   // word starts on a word-clock pulse
    } aso_fmt_e;

endpackage

// File: rtl/aso_sync.sv
// Multi-bit level synchronizer.
// Assumes each input bit is an independent slow level; every bit passes
// through STAGES flops in the system clock domain.
module aso_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end

        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/aso_framer.sv
// Bit-period framer.
// Finds the launch edge of the synchronized bit clock and counts bit periods
// from the last word start. For each launch it reports whether the period
// carries a data bit, which bit that is, and which channel.
// Assumes lrclk and wclk change together with the launch edge of bclk.
module aso_framer
    import aso_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int HALF_LEN = 32,
    parameter int BIT_W    = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             lrclk_s,
    input  logic             wclk_s,
    input  logic             pol_in,
    input  logic [1:0]       fmt_in,
    input  logic             mute_in,
    output logic             launch,
    output logic             frame_start,
    output logic             in_word,
    output logic             chan_left,
    output logic             mute_now,
    output logic [BIT_W-1:0] bit_pos
);

    localparam int CNT_W = $clog2(2 * HALF_LEN);
    localparam logic [CNT_W:0] OFF_RJ = (CNT_W+1)'(HALF_LEN - WORD_W);
    localparam logic [CNT_W:0] OFF_DLY = (CNT_W+1)'(1);
    localparam logic [CNT_W:0] W_EXT  = (CNT_W+1)'(WORD_W);

    logic             bclk_last;
    logic             lr_last;
    logic             wck_last;
    logic             pol_q;
    logic             mute_q;
    aso_fmt_e         fmt_q;
    aso_fmt_e         fmt_cur;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_cur;
    logic             chan_q;
    logic             lr_edge;
    logic             wck_start;
    logic             word_start;
    logic [CNT_W:0]   cnt_ext;
    logic [CNT_W:0]   offset;
    logic [CNT_W:0]   rel;

    // Track the bit clock every system cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_last <= 1'b0;
        else        bclk_last <= bclk_s;
    end

    // Launch edge chosen by the captured polarity.
    assign launch = pol_q ? (bclk_s & ~bclk_last) : (~bclk_s & bclk_last);

    // Frame-clock and word-clock events seen at launch edges.
    assign lr_edge     = launch && (lrclk_s != lr_last);
    assign frame_start = launch && lrclk_s && !lr_last;
    assign wck_start   = launch && wclk_s && !wck_last;

    // Settings in force for this period: new ones apply from a frame start.
    assign fmt_cur  = frame_start ? aso_fmt_e'(fmt_in) : fmt_q;
    assign mute_now = frame_start ? mute_in : mute_q;

    // Word start event depends on the active format.
    assign word_start = (fmt_cur == FMT_WCK) ? wck_start : lr_edge;

    // Period count since word start, saturating while idle.
    always_comb begin
        if (word_start)       cnt_cur = '0;
        else if (&cnt_q)      cnt_cur = cnt_q;
        else                  cnt_cur = cnt_q + 1'b1;
    end

    assign chan_left = word_start ? lrclk_s : chan_q;

    // MSB delay of the active format.
    always_comb begin
        case (fmt_cur)
            FMT_LJ_DLY: offset = OFF_DLY;
            FMT_RJ:     offset = OFF_RJ;
            default:    offset = '0;
        endcase
    end

    assign cnt_ext = {1'b0, cnt_cur};
    assign rel     = cnt_ext - offset;
    assign in_word = (cnt_ext >= offset) && (cnt_ext < offset + W_EXT);
    assign bit_pos = BIT_W'(WORD_W - 1) - rel[BIT_W-1:0];

    // Per-launch state: counter, channel and last clock levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '1;
            chan_q   <= 1'b0;
            lr_last  <= 1'b0;
            wck_last <= 1'b0;
        end else if (launch) begin
            cnt_q    <= cnt_cur;
            chan_q   <= chan_left;
            lr_last  <= lrclk_s;
            wck_last <= wclk_s;
        end
    end

    // Settings captured at reset and at each frame start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= pol_in;
            fmt_q  <= FMT_LJ;
            mute_q <= 1'b0;
        end else if (frame_start) begin
            pol_q  <= pol_in;
            fmt_q  <= aso_fmt_e'(fmt_in);
            mute_q <= mute_in;
        end
    end

endmodule

// File: rtl/aso_shifter.sv
// Sample holder and serial output stage.
// Captures the stereo pair at a frame start and, on each launch, drives the
// selected bit of the current word (or zero) onto the serial line.
// Assumes bit_pos is meaningful only when in_word is set.
module aso_shifter #(
    parameter int WORD_W = 16,
    parameter int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              frame_start,
    input  logic              in_word,
    input  logic              chan_left,
    input  logic              mute_now,
    input  logic [BIT_W-1:0]  bit_pos,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdata,
    output logic              sample_req
);

    logic [WORD_W-1:0] left_q;
    logic [WORD_W-1:0] right_q;
    logic [WORD_W-1:0] left_cur;
    logic [WORD_W-1:0] right_cur;
    logic [WORD_W-1:0] word;

    // At a frame start the fresh inputs are used directly.
    assign left_cur  = frame_start ? left_in  : left_q;
    assign right_cur = frame_start ? right_in : right_q;
    assign word      = chan_left ? left_cur : right_cur;

    // Hold the pair for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (frame_start) begin
            left_q  <= left_in;
            right_q <= right_in;
        end
    end

    // Drive one bit per launch edge; zero outside data or when muted.
    always_ff @(posedge clk) begin
        if (!rst_n)       sdata <= 1'b0;
        else if (launch)  sdata <= in_word && !mute_now && word[bit_pos];
    end

    // Ask for the next pair right after capturing this one.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_req <= 1'b0;
        else        sample_req <= frame_start;
    end

endmodule

// File: rtl/aso_serial_tx.sv
// Multi-format serial audio transmitter (top).
// Synchronizes the external clocks, frames each bit period and serializes
// the latched stereo pair. Assumes clk runs at least ~8x the bit clock.
module aso_serial_tx #(
    parameter int WORD_W   = 16,
    parameter int HALF_LEN = 32,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              lrclk,
    input  logic              wclk,
    input  logic              bclk_pol,
    input  logic [1:0]        fmt,
    input  logic              mute,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdata,
    output logic              sample_req
);

    localparam int BIT_W = $clog2(WORD_W);

    logic [2:0]       clk_sync;
    logic             launch;
    logic             frame_start;
    logic             in_word;
    logic             chan_left;
    logic             mute_now;
    logic [BIT_W-1:0] bit_pos;

    aso_sync #(.N(3), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({wclk, lrclk, bclk}),
        .dout  (clk_sync)
    );

    aso_framer #(.WORD_W(WORD_W), .HALF_LEN(HALF_LEN), .BIT_W(BIT_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_s      (clk_sync[0]),
        .lrclk_s     (clk_sync[1]),
        .wclk_s      (clk_sync[2]),
        .pol_in      (bclk_pol),
        .fmt_in      (fmt),
        .mute_in     (mute),
        .launch      (launch),
        .frame_start (frame_start),
        .in_word     (in_word),
        .chan_left   (chan_left),
        .mute_now    (mute_now),
        .bit_pos     (bit_pos)
    );

    aso_shifter #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .frame_start (frame_start),
        .in_word     (in_word),
        .chan_left   (chan_left),
        .mute_now    (mute_now),
        .bit_pos     (bit_pos),
        .left_in     (left_in),
        .right_in    (right_in),
        .sdata       (sdata),
        .sample_req  (sample_req)
    );

endmodule

// File: rtl/aso_serial_tx_chk.sv
// Property checker for the serial audio transmitter, bound to the top.
module aso_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic launch,
    input logic frame_start,
    input logic in_word,
    input logic mute_now,
    input logic sdata,
    input logic sample_req
);

    AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(sdata)); // R2

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !in_word) |=> !sdata); // R8

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && mute_now) |=> !sdata); // R9

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> sample_req); // R12

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req); // R12

endmodule

bind aso_serial_tx aso_serial_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .frame_start (frame_start),
    .in_word     (in_word),
    .mute_now    (mute_now),
    .sdata       (sdata),
    .sample_req  (sample_req)
);

// File: tb/tb_aso_serial_tx.sv
module tb_aso_serial_tx;

    localparam int HALF_CLK = 6;
    localparam int WD_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        lrclk = 1'b0;
    logic        wclk = 1'b0;
    logic        bclk_pol = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        mute = 1'b0;
    logic [15:0] left_in = '0;
    logic [15:0] right_in = '0;
    logic        sdata;
    logic        sample_req;

    int n_cmp = 0;
    int n_bad = 0;
    int req_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    aso_serial_tx dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .wclk(wclk),
        .bclk_pol(bclk_pol), .fmt(fmt), .mute(mute),
        .left_in(left_in), .right_in(right_in),
        .sdata(sdata), .sample_req(sample_req)
    );

    // Count system cycles with the request strobe high.
    always @(posedge clk) if (rst_n && sample_req) req_cnt <= req_cnt + 1;

    // Expected bit: position s (0..31) in a half-frame, word w, format m.
    function automatic bit in_data(input logic [1:0] m, input int s);
        case (m)
            2'b00:   return s < 16;
            2'b01:   return s >= 1 && s <= 16;
            2'b10:   return s >= 16;
            default: return s >= 4 && s < 20;
        endcase
    endfunction

    function automatic bit exp_bit(input logic [1:0] m, input logic [15:0] w, input int s);
        if (!in_data(m, s)) return 1'b0;
        case (m)
            2'b00:   return w[15-s];
            2'b01:   return w[16-s];
            2'b10:   return w[31-s];
            default: return w[19-s];
        endcase
    endfunction

    task automatic chk(input bit act, input bit exp, input string tag, input int fr, input int sl);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: frame %0d slot %0d sdata=%0b expected %0b", tag, fr, sl, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One bit period: launch half then sampling half, both checked.
    task automatic slot(input bit lr, input bit wc, input bit e, input string tag, input int fr, input int sl);
        @(negedge clk);
        bclk = bclk_pol; lrclk = lr; wclk = wc;
        repeat (HALF_CLK - 1) @(negedge clk);
        chk(sdata, e, tag, fr, sl);
        @(negedge clk);
        bclk = ~bclk_pol;
        repeat (HALF_CLK - 1) @(negedge clk);
        chk(sdata, e, "R2", fr, sl);
    endtask

    // One full frame; optional random input change partway through (R10, R11).
    task automatic do_frame(input int fr, input bit chg);
        logic [1:0] m = fmt;
        bit mu = mute;
        logic [15:0] wl = left_in;
        logic [15:0] wr = right_in;
        int cs = chg ? int'($urandom_range(63, 1)) : 64;
        int rq0 = req_cnt;
        for (int gs = 0; gs < 64; gs++) begin
            int s = gs % 32;
            bit lr = (gs < 32);
            bit e = mu ? 1'b0 : exp_bit(m, lr ? wl : wr, s);
            string tag;
            if (gs > cs)               tag = "R10_R11";
            else if (mu)               tag = "R9";
            else if (!in_data(m, s))   tag = "R8";
            else if (!lr)              tag = "R7";
            else if (m == 2'b00)       tag = "R3";
            else if (m == 2'b01)       tag = "R4";
            else if (m == 2'b10)       tag = "R5";
            else                       tag = "R6";
            slot(lr, s == 4, e, tag, fr, gs);
            if (gs == 0) chk_int(req_cnt - rq0, 1, "R12 request pulse");
            if (gs == cs) begin
                fmt = 2'($urandom_range(3, 0));
                mute = ($urandom_range(3, 0) == 0);
                left_in = 16'($urandom);
                right_in = 16'($urandom);
            end
        end
    endtask

    task automatic set_in(input logic [1:0] m, input bit mu, input logic [15:0] l, input logic [15:0] r);
        fmt = m; mute = mu; left_in = l; right_in = r;
    endtask

    task automatic start_run(input bit p);
        @(negedge clk);
        rst_n = 0; bclk_pol = p; bclk = ~p; lrclk = 0; wclk = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(sdata, 1'b0, "R1", -1, -1);
        chk_int(int'(sample_req), 0, "R1 request idle");
        begin
            int rq0 = req_cnt;
            for (int i = 0; i < 4; i++) slot(1'b0, 1'b0, 1'b0, "R1", -1, i);
            chk_int(req_cnt - rq0, 0, "R1 no request before frame");
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        int fr = 0;
        void'($urandom(32'd2024));
        // Falling-edge launch, directed formats first.
        set_in(2'b00, 0, 16'h8001, 16'h7FFE);
        start_run(1'b0);
        do_frame(fr++, 0);
        set_in(2'b01, 0, 16'hA5C3, 16'h3C5A); do_frame(fr++, 0);
        set_in(2'b10, 0, 16'hFFFF, 16'h0001); do_frame(fr++, 0);
        set_in(2'b11, 0, 16'h1234, 16'hFEDC); do_frame(fr++, 0);
        set_in(2'b00, 1, 16'hFFFF, 16'hFFFF); do_frame(fr++, 0);
        set_in(2'b11, 1, 16'hFFFF, 16'h8000); do_frame(fr++, 0);
        for (int i = 0; i < 30; i++) do_frame(fr++, 1);
        // Rising-edge launch.
        set_in(2'b00, 0, 16'h4C1F, 16'hC3E0);
        start_run(1'b1);
        do_frame(fr++, 0);
        set_in(2'b01, 0, 16'h0F0F, 16'hF0F0); do_frame(fr++, 0);
        set_in(2'b10, 0, 16'h8000, 16'h0001); do_frame(fr++, 0);
        set_in(2'b11, 0, 16'hBEEF, 16'h1357); do_frame(fr++, 0);
        for (int i = 0; i < 12; i++) do_frame(fr++, 1);
        done = 1;
        summary();
        $finish;
    end

endmodule